// File: doc/BRIEF.md
# Streaming Row Dilation and Erosion Unit

This unit applies a flat one-dimensional grey-level dilation or erosion along each image row as pixels stream through it. Each result is the maximum (dilation) or minimum (erosion) of the pixels that fall inside a horizontal segment. The segment's length and the position of its origin are set at run time, up to a limit fixed at elaboration. The unit keeps a short queue of candidate pixels whose values only ever fall (for dilation) or only ever rise (for erosion). Each queue entry holds a pixel value and its column. A new pixel removes every entry at the tail of the queue that it dominates. The entry at the head leaves the queue once its column has slid out of the window. The work per pixel is therefore the same for any segment length, and the input is read strictly left to right.

A bypass setting turns the queue into a plain first-in first-out delay. Results then equal the input pixels, but they appear with the same timing as in the active mode. A parallel branch of a larger pipeline can use this to stay aligned. Pixels enter and results leave on valid/ready streams in raster order. The row width is a run-time setting. Once the last pixel of a row has arrived, the unit flushes the remaining results of that row before it accepts the next row.

Top module: `line_dil_top`

## Requirements
- R1: With cfg_erode = 0 (dilation), the result for column x of a row of width W is the maximum of the input pixels at columns x-org .. x-org+len-1 that lie within 0 .. W-1.
- R2: With cfg_erode = 1 (erosion), the result for column x is the minimum over that same clipped window.
- R3: cfg_len (1 .. LEN_MAX) and cfg_org (0 .. cfg_len-1) can be changed between rows. The values present when a row's first pixel is accepted govern the whole of that row, and the queue never holds more than LEN_MAX entries.
- R4: Columns outside the row contribute the neutral value: 0 for dilation and 255 for erosion. No pixel of one row affects a result of another row.
- R5: A row of cfg_width pixels (1 .. WIDTH_MAX) yields exactly cfg_width results in column order. The first pixel of a row is not accepted until every result of the previous row has been handed off.
- R6: While out_valid is high and out_ready is low, out_data stays stable, out_valid stays high, and in_ready is low.
- R7: With cfg_bypass = 1, the result for column x equals the input pixel at column x.
- R8: After reset, out_valid is low and in_ready is high.
- R9: In every mode, a row's first result appears only after exactly min(W, cfg_len-cfg_org) of its pixels have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | $clog2(WIDTH_MAX+1) | Row width in pixels |
| cfg_len | input | $clog2(LEN_MAX+1) | Segment length |
| cfg_org | input | $clog2(LEN_MAX+1) | Origin offset within the segment |
| cfg_erode | input | 1 | 0 selects dilation, 1 selects erosion |
| cfg_bypass | input | 1 | 1 selects the pure delay mode |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Unit accepts the input pixel |
| in_data | input | 8 | Input pixel |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 8 | Result pixel |

## Verification
The assertions check the result-port handshake rule on every cycle: a result that is held stays stable, and input is blocked while it is held. They also check that the queue never exceeds its bound and that the row's result count never passes its pixel count. The bench's scenarios are what show the values themselves. It compares each result with the clipped window maximum or minimum, and it covers bypass. It checks the number of pixels accepted before a row's first result and the flush ordering between rows. It does this across long and short segments, origins at both ends of the segment, rows narrower than the segment, ramps and ties, and random downstream stalls.

// File: rtl/line_dil_pkg.sv
package line_dil_pkg;

  localparam int unsigned PIX_W = 8;

  typedef logic [PIX_W-1:0] pix_t;

  typedef enum logic {
    MODE_DIL = 1'b0,
    MODE_ERO = 1'b1
  } morph_mode_e;

  // True when a newer pixel makes an older queued one useless.
  function automatic logic dominates(morph_mode_e m, pix_t fresh, pix_t old);
    return (m == MODE_DIL) ? (fresh >= old) : (fresh <= old);
  endfunction

endpackage

// File: rtl/line_dil_queue.sv
module line_dil_queue
  import line_dil_pkg::*;
#(
  parameter int unsigned WIDTH_MAX = 64,
  parameter int unsigned LEN_MAX   = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               push_en,
  input  pix_t                               push_val,
  input  logic [$clog2(WIDTH_MAX)-1:0]       push_pos,
  input  logic                               emit_en,
  input  logic [$clog2(WIDTH_MAX+1)-1:0]     win_lo,
  input  logic [$clog2(LEN_MAX+1)-1:0]       org_exp,
  input  morph_mode_e                        mode,
  input  logic                               keep_all,
  input  logic                               clear,
  output pix_t                               front_val,
  output logic [$clog2(LEN_MAX+2)-1:0]       occ
);
  localparam int unsigned DEPTH = LEN_MAX + 1;
  localparam int unsigned PW    = $clog2(WIDTH_MAX);
  localparam int unsigned CW    = $clog2(WIDTH_MAX + 1);
  localparam int unsigned LW    = $clog2(LEN_MAX + 1);
  localparam int unsigned NW    = $clog2(DEPTH + 1);
  localparam int unsigned AW    = CW + LW + 1;

  pix_t          val_q [DEPTH];
  logic [PW-1:0] pos_q [DEPTH];
  logic [NW-1:0] cnt_q, cnt_d;

  pix_t          a_val [DEPTH];
  logic [PW-1:0] a_pos [DEPTH];
  pix_t          b_val [DEPTH];
  logic [PW-1:0] b_pos [DEPTH];
  logic [NW-1:0] keep, a_cnt, b_cnt;
  logic          expire;
  logic          upd_en;

  always_comb begin
    // tail pops: surviving entries form a prefix because the queue is monotonic
    keep = cnt_q;
    if (!keep_all) begin
      keep = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if ((NW'(i) < cnt_q) && !dominates(mode, push_val, val_q[i])) keep = keep + NW'(1);
      end
    end
    a_val = val_q;
    a_pos = pos_q;
    a_cnt = cnt_q;
    if (push_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (NW'(i) == keep) begin
          a_val[i] = push_val;
          a_pos[i] = push_pos;
        end
      end
      a_cnt = keep + NW'(1);
    end
    // head pop: at most one column leaves the window per result
    expire = emit_en && (a_cnt != '0) &&
             ((AW'(a_pos[0]) + AW'(org_exp)) < AW'(win_lo));
    b_val = a_val;
    b_pos = a_pos;
    b_cnt = a_cnt;
    if (expire) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        b_val[i] = a_val[i+1];
        b_pos[i] = a_pos[i+1];
      end
      b_cnt = a_cnt - NW'(1);
    end
    front_val = b_val[0];
    cnt_d     = clear ? '0 : b_cnt;
    upd_en    = push_en | emit_en | clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      val_q <= b_val;
      pos_q <= b_pos;
    end
  end

  assign occ = cnt_q;

endmodule

// File: rtl/line_dil_ctrl.sv
module line_dil_ctrl
  import line_dil_pkg::*;
#(
  parameter int unsigned WIDTH_MAX = 64,
  parameter int unsigned LEN_MAX   = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(WIDTH_MAX+1)-1:0]     cfg_width,
  input  logic [$clog2(LEN_MAX+1)-1:0]       cfg_len,
  input  logic [$clog2(LEN_MAX+1)-1:0]       cfg_org,
  input  logic                               cfg_erode,
  input  logic                               cfg_bypass,
  input  logic                               in_valid,
  input  logic                               out_ready,
  input  pix_t                               front_val,
  output logic                               in_ready,
  output logic                               push_en,
  output logic [$clog2(WIDTH_MAX)-1:0]       push_pos,
  output logic                               emit_en,
  output logic                               clear,
  output logic [$clog2(WIDTH_MAX+1)-1:0]     in_cnt,
  output logic [$clog2(WIDTH_MAX+1)-1:0]     out_cnt,
  output logic [$clog2(LEN_MAX+1)-1:0]       org_exp,
  output morph_mode_e                        mode,
  output logic                               keep_all,
  output logic                               out_valid,
  output pix_t                               out_data
);
  localparam int unsigned PW = $clog2(WIDTH_MAX);
  localparam int unsigned CW = $clog2(WIDTH_MAX + 1);
  localparam int unsigned LW = $clog2(LEN_MAX + 1);
  localparam int unsigned AW = CW + LW + 1;

  logic [CW-1:0] in_cnt_q, in_cnt_d, out_cnt_q, out_cnt_d, in_nxt;
  logic [CW-1:0] w_q, w_eff;
  logic [LW-1:0] len_q, org_q, len_eff, org_eff, la;
  morph_mode_e   mode_q, mode_eff;
  logic          byp_q, byp_eff;
  logic          out_valid_q, out_valid_d;
  pix_t          out_data_q, out_data_d;
  logic          idle, slot_free, last;

  always_comb begin
    idle      = (in_cnt_q == '0) && (out_cnt_q == '0);
    w_eff     = idle ? cfg_width : w_q;
    len_eff   = idle ? cfg_len : len_q;
    org_eff   = idle ? cfg_org : org_q;
    mode_eff  = idle ? morph_mode_e'(cfg_erode) : mode_q;
    byp_eff   = idle ? cfg_bypass : byp_q;
    la        = len_eff - org_eff - LW'(1);
    slot_free = !out_valid_q || out_ready;
    in_ready  = (in_cnt_q < w_eff) && slot_free;
    push_en   = in_valid && in_ready;
    in_nxt    = in_cnt_q + CW'(push_en);
    emit_en   = slot_free && (out_cnt_q < w_eff) &&
                ((in_nxt == w_eff) || (AW'(in_nxt) > (AW'(out_cnt_q) + AW'(la))));
    last      = emit_en && (out_cnt_q == (w_eff - CW'(1)));
    clear     = last;
    in_cnt_d  = last ? '0 : in_nxt;
    out_cnt_d = last ? '0 : (out_cnt_q + CW'(emit_en));
    out_valid_d = emit_en ? 1'b1 : (out_ready ? 1'b0 : out_valid_q);
    out_data_d  = emit_en ? front_val : out_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt_q    <= '0;
      out_cnt_q   <= '0;
      out_valid_q <= 1'b0;
      w_q         <= '0;
      len_q       <= '0;
      org_q       <= '0;
      mode_q      <= MODE_DIL;
      byp_q       <= 1'b0;
    end else begin
      in_cnt_q    <= in_cnt_d;
      out_cnt_q   <= out_cnt_d;
      out_valid_q <= out_valid_d;
      if (idle) begin
        w_q    <= cfg_width;
        len_q  <= cfg_len;
        org_q  <= cfg_org;
        mode_q <= morph_mode_e'(cfg_erode);
        byp_q  <= cfg_bypass;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (emit_en) out_data_q <= out_data_d;
  end

  assign push_pos  = PW'(in_cnt_q);
  assign in_cnt    = in_cnt_q;
  assign out_cnt   = out_cnt_q;
  assign org_exp   = byp_eff ? '0 : org_eff;
  assign mode      = mode_eff;
  assign keep_all  = byp_eff;
  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

endmodule

// File: rtl/line_dil_top.sv
module line_dil_top
  import line_dil_pkg::*;
#(
  parameter int unsigned WIDTH_MAX = 64,
  parameter int unsigned LEN_MAX   = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(WIDTH_MAX+1)-1:0]     cfg_width,
  input  logic [$clog2(LEN_MAX+1)-1:0]       cfg_len,
  input  logic [$clog2(LEN_MAX+1)-1:0]       cfg_org,
  input  logic                               cfg_erode,
  input  logic                               cfg_bypass,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [7:0]                         in_data,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [7:0]                         out_data
);
  localparam int unsigned PW = $clog2(WIDTH_MAX);
  localparam int unsigned CW = $clog2(WIDTH_MAX + 1);
  localparam int unsigned LW = $clog2(LEN_MAX + 1);
  localparam int unsigned NW = $clog2(LEN_MAX + 2);

  logic          push_en, emit_en, clear, keep_all;
  logic [PW-1:0] push_pos;
  logic [CW-1:0] row_in_cnt, row_out_cnt;
  logic [LW-1:0] org_exp;
  morph_mode_e   mode;
  pix_t          front_val;
  logic [NW-1:0] q_occ;

  line_dil_ctrl #(.WIDTH_MAX(WIDTH_MAX), .LEN_MAX(LEN_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_width(cfg_width), .cfg_len(cfg_len), .cfg_org(cfg_org),
    .cfg_erode(cfg_erode), .cfg_bypass(cfg_bypass),
    .in_valid(in_valid), .out_ready(out_ready), .front_val(front_val),
    .in_ready(in_ready), .push_en(push_en), .push_pos(push_pos),
    .emit_en(emit_en), .clear(clear),
    .in_cnt(row_in_cnt), .out_cnt(row_out_cnt),
    .org_exp(org_exp), .mode(mode), .keep_all(keep_all),
    .out_valid(out_valid), .out_data(out_data)
  );

  line_dil_queue #(.WIDTH_MAX(WIDTH_MAX), .LEN_MAX(LEN_MAX)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_en), .push_val(in_data), .push_pos(push_pos),
    .emit_en(emit_en), .win_lo(row_out_cnt), .org_exp(org_exp),
    .mode(mode), .keep_all(keep_all), .clear(clear),
    .front_val(front_val), .occ(q_occ)
  );

endmodule

// File: rtl/line_dil_chk.sv
module line_dil_chk #(
  parameter int unsigned WIDTH_MAX = 64,
  parameter int unsigned LEN_MAX   = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_ready,
  input logic                           out_valid,
  input logic                           out_ready,
  input logic [7:0]                     out_data,
  input logic [$clog2(LEN_MAX+2)-1:0]   q_occ,
  input logic [$clog2(WIDTH_MAX+1)-1:0] row_in_cnt,
  input logic [$clog2(WIDTH_MAX+1)-1:0] row_out_cnt
);
  localparam int unsigned NW = $clog2(LEN_MAX + 2);

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_in_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_occ <= NW'(LEN_MAX));

  p_cnt_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    row_out_cnt <= row_in_cnt);

endmodule

bind line_dil_top line_dil_chk #(.WIDTH_MAX(WIDTH_MAX), .LEN_MAX(LEN_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .q_occ(q_occ),
  .row_in_cnt(row_in_cnt), .row_out_cnt(row_out_cnt)
);

// File: tb/tb_line_dil_top.sv
module tb_line_dil_top;
  localparam int WIDTH_MAX = 64;
  localparam int LEN_MAX   = 16;
  localparam int CW = $clog2(WIDTH_MAX + 1);
  localparam int LW = $clog2(LEN_MAX + 1);

  logic          clk, rst_n;
  logic [CW-1:0] cfg_width;
  logic [LW-1:0] cfg_len, cfg_org;
  logic          cfg_erode, cfg_bypass;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [7:0]    in_data, out_data;

  int    n_checks, n_errors;
  int    exp_val[$];
  int    exp_first[$];
  string exp_tag[$];
  int    bnd_q[$];
  int    acc_total, out_total, acc_base;
  bit    bp_en;
  logic [7:0] lfsr;

  line_dil_top #(.WIDTH_MAX(WIDTH_MAX), .LEN_MAX(LEN_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_len(cfg_len),
    .cfg_org(cfg_org), .cfg_erode(cfg_erode), .cfg_bypass(cfg_bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic int pix_gen(int kind, int seed, int i);
    case (kind)
      1: return (i * 3 + seed) % 256;
      2: return (250 - i * 3 + 256) % 256;
      3: return seed % 256;
      default: begin
        if (i % 9 == 4) return 255;
        if (i % 11 == 7) return 0;
        return (i * 73 + seed * 41 + ((i * i) % 13) * 19) % 256;
      end
    endcase
  endfunction

  task automatic send_row(int w, int len, int org, bit ero, bit byp,
                          int kind, int seed, bit gaps, string tag);
    int pix[WIDTH_MAX];
    int la;
    for (int i = 0; i < w; i++) pix[i] = pix_gen(kind, seed, i);
    la = len - 1 - org;
    for (int x = 0; x < w; x++) begin
      int acc;
      if (byp) acc = pix[x];
      else begin
        acc = ero ? 255 : 0;
        for (int k = 0; k < len; k++) begin
          int p;
          p = x - org + k;
          if (p >= 0 && p < w) begin
            if (ero) acc = (pix[p] < acc) ? pix[p] : acc;
            else     acc = (pix[p] > acc) ? pix[p] : acc;
          end
        end
      end
      exp_val.push_back(acc);
      exp_tag.push_back(tag);
      exp_first.push_back(x == 0 ? acc_base + ((w < la + 1) ? w : la + 1) : -1);
    end
    bnd_q.push_back(acc_base);
    cfg_width  = CW'(w);
    cfg_len    = LW'(len);
    cfg_org    = LW'(org);
    cfg_erode  = ero;
    cfg_bypass = byp;
    for (int i = 0; i < w; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(pix[i]);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    acc_base += w;
  endtask

  // downstream backpressure
  initial begin
    out_ready = 1'b1;
    lfsr = 8'hA5;
    forever begin
      @(posedge clk); #1;
      if (bp_en) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = lfsr[0] | lfsr[3];
      end else out_ready = 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid && out_ready) begin
          if (exp_val.size() == 0) check(1'b0, "R5 unexpected result", out_data, -1);
          else begin
            int ev, ef;
            string et;
            ev = exp_val.pop_front();
            ef = exp_first.pop_front();
            et = exp_tag.pop_front();
            check(out_data == 8'(ev), et, out_data, ev);
            if (ef >= 0) check(acc_total == ef, "R9 pixels before first result", acc_total, ef);
          end
          out_total++;
        end
        if (in_valid && in_ready) begin
          if (bnd_q.size() != 0 && acc_total == bnd_q[0]) begin
            check(out_total == acc_total, "R5 previous row flushed", out_total, acc_total);
            void'(bnd_q.pop_front());
          end
          acc_total++;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    n_checks = 0; n_errors = 0;
    acc_total = 0; out_total = 0; acc_base = 0;
    bp_en = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0;
    cfg_width = CW'(8); cfg_len = LW'(3); cfg_org = LW'(1);
    cfg_erode = 1'b0; cfg_bypass = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R8 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    send_row(20, 5, 2, 1'b0, 1'b0, 0, 3, 1'b0, "R1 dilation len5 org2");
    send_row(20, 5, 2, 1'b1, 1'b0, 0, 3, 1'b0, "R2 erosion len5 org2");
    send_row(8, 1, 0, 1'b0, 1'b0, 0, 9, 1'b0, "R3 len1 identity");
    send_row(10, 16, 0, 1'b0, 1'b0, 2, 0, 1'b0, "R4 dilation window wider than row");
    send_row(32, 16, 15, 1'b1, 1'b0, 0, 5, 1'b0, "R4 erosion origin at segment end");
    send_row(1, 7, 6, 1'b0, 1'b0, 0, 2, 1'b0, "R5 single pixel row");
    send_row(24, 9, 3, 1'b0, 1'b1, 0, 7, 1'b0, "R7 bypass delay");
    bp_en = 1'b1;
    send_row(40, 4, 1, 1'b1, 1'b0, 0, 11, 1'b1, "R6 erosion under backpressure");
    send_row(16, 3, 1, 1'b0, 1'b0, 3, 77, 1'b0, "R1 ties constant row");
    send_row(16, 6, 0, 1'b1, 1'b0, 1, 4, 1'b1, "R2 erosion rising ramp");
    send_row(64, 16, 0, 1'b0, 1'b1, 0, 13, 1'b0, "R7 bypass full width");
    send_row(64, 16, 8, 1'b0, 1'b0, 0, 17, 1'b1, "R3 max length centred origin");
    bp_en = 1'b0;

    while (exp_val.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(exp_val.size() == 0, "R5 all results delivered", exp_val.size(), 0);
    check(out_total == acc_total, "R5 result count equals pixel count", out_total, acc_total);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule